// File: doc/BRIEF.md
# Triggered One-Pulse Timer Channel

This block is an up-counting timer with a single compare channel. A slave controller starts, restarts or gates the counter from one of several trigger sources. Each source comes from two external inputs after a two-flop synchroniser. The channel output is built from the count and two programmable values. The compare value sets how long the output waits before it goes active. The auto-reload value sets where the counter wraps to zero, which ends the active phase. In one-shot operation the counter switches itself off when it wraps. A single trigger then yields exactly one delayed pulse of programmable width. With one-shot clear the pulse repeats every auto-reload + 1 counts.

Software programs the block through a small write port. The port holds a control word, the compare and auto-reload values, each with optional double buffering, and a command word whose bit 0 forces an update. An optional fast path drives the output to its matched level on the start trigger itself. This removes the compare delay from the trigger-to-output latency. A polarity bit inverts the final output.

Top module: `pulse_timer`

## Requirements
- R1: With one-shot (control bit 0) set, the counter clears its own run enable in the cycle it wraps from the auto-reload value to 0, so no further pulse follows without a new trigger. With one-shot clear the counter keeps running and the pulse repeats with a period of auto-reload + 1 cycles.
- R2: In trigger mode, let edge index 0 be the first rising clock edge after a raw trigger change. With fast off, the output becomes active at index compare + 3 and stays active for auto-reload − compare + 1 cycles, going inactive at index auto-reload + 4.
- R3: Control bit 1 selects the compare rule. With it set (mode 2) the reference is active when count ≥ compare. With it clear (mode 1) the reference is active when count < compare, so the output idles active and drops at the match.
- R4: If the compare value is greater than the auto-reload value, a triggered run gives no active output level.
- R5: Trigger select (control bits 8:6) takes these codes. 110 selects the synchronised level of input B. 101 selects the synchronised level of input A. 100 selects an edge detector on input A that fires on both its rising and falling edges. Every other code selects no trigger. A trigger on an unselected input has no effect.
- R6: Slave mode (control bits 11:9) 110 is trigger mode: a trigger rising edge sets the run enable without changing the count.
- R7: Slave mode 100 is reset mode: a trigger rising edge sets the count to 0 and performs an update event while the counter keeps running.
- R8: Slave mode 101 is gated mode: the counter advances only while the selected trigger level is high, and holds its value while the level is low.
- R9: With compare preload (control bit 3) set, a compare write lands in a buffer and reaches the active compare value only at an update event. With the bit clear, a write takes effect at once.
- R10: With auto-reload preload (control bit 4) set, an auto-reload write reaches the active value only at an update event. Otherwise it takes effect at once.
- R11: With fast (control bit 2) set, a trigger-mode start forces the reference to its matched level (active in mode 2), so the output becomes active at edge index 3. Normal comparison resumes after the next update event.
- R12: Polarity (control bit 5) inverts the output: 0 is active high and 1 is active low.
- R13: Writing 1 to bit 0 of the command word (address 3) clears the count and copies both buffers to the active values.
- R14: Write address 0 is the control word, and its bit 12 loads the run enable. Address 1 is the compare value, address 2 the auto-reload value and address 3 the command word. After reset all registers and the count are zero and the output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | W | Write data |
| trig_a | input | 1 | Asynchronous trigger input A |
| trig_b | input | 1 | Asynchronous trigger input B |
| pulse_out | output | 1 | Registered channel output after polarity |

## Verification
Every output result is counted in rising clock edges from index 0, the first edge that samples a changed trigger pin. Two synchroniser stages and one run-enable register mean that a trigger-mode start shows at index compare + 3 without fast and at index 3 with it. The end of the pulse falls at index auto-reload + 4. In gated mode the count advances from index 2 onward, so the output rises at index compare − (count already held) + 2. The bench changes trigger pins on falling edges only, then samples the output after each following rising edge while it keeps the index. It compares the first active index and the first later inactive index with these formulas.

// File: rtl/pt_pkg.sv
`timescale 1ns/1ps
package pt_pkg;
  localparam int CTRL_BITS = 12;
  localparam int RUN_BIT   = 12;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CMP  = 2'd1;
  localparam logic [1:0] A_ARR  = 2'd2;
  localparam logic [1:0] A_CMD  = 2'd3;

  localparam logic [2:0] TS_EDGE_A = 3'b100;
  localparam logic [2:0] TS_LVL_A  = 3'b101;
  localparam logic [2:0] TS_LVL_B  = 3'b110;

  localparam logic [2:0] SM_RESET = 3'b100;
  localparam logic [2:0] SM_GATED = 3'b101;
  localparam logic [2:0] SM_TRIG  = 3'b110;

  typedef struct packed {
    logic [2:0] sm;
    logic [2:0] ts;
    logic       pol;
    logic       arr_pe;
    logic       cmp_pe;
    logic       fast;
    logic       mode2;
    logic       oneshot;
  } ctrl_t;
endpackage

// File: rtl/pt_sync.sv
`timescale 1ns/1ps
module pt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], din};
  end

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/pt_trig.sv
`timescale 1ns/1ps
module pt_trig
  import pt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] lvl,
  input  logic [2:0] sel,
  output logic       trig_lvl,
  output logic       trig_rise
);
  logic a_d;
  logic trig_d;

  always_comb begin
    case (sel)
      TS_EDGE_A: trig_lvl = lvl[0] ^ a_d;
      TS_LVL_A:  trig_lvl = lvl[0];
      TS_LVL_B:  trig_lvl = lvl[1];
      default:   trig_lvl = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_d    <= 1'b0;
      trig_d <= 1'b0;
    end else begin
      a_d    <= lvl[0];
      trig_d <= trig_lvl;
    end
  end

  assign trig_rise = trig_lvl & ~trig_d;
endmodule

// File: rtl/pt_regs.sv
`timescale 1ns/1ps
module pt_regs
  import pt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         upd,
  output ctrl_t        ctrl_q,
  output logic [W-1:0] cmp_act,
  output logic [W-1:0] arr_act,
  output logic         ug,
  output logic         run_wr,
  output logic         run_val
);
  logic [W-1:0] cmp_pre;
  logic [W-1:0] arr_pre;
  logic wr_cmp, wr_arr;

  assign run_wr  = wr_en && (wr_addr == A_CTRL);
  assign run_val = wr_data[RUN_BIT];
  assign wr_cmp  = wr_en && (wr_addr == A_CMP);
  assign wr_arr  = wr_en && (wr_addr == A_ARR);
  assign ug      = wr_en && (wr_addr == A_CMD) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      cmp_pre <= '0;
      cmp_act <= '0;
      arr_pre <= '0;
      arr_act <= '0;
    end else begin
      if (run_wr) ctrl_q <= wr_data[CTRL_BITS-1:0];
      if (wr_cmp) cmp_pre <= wr_data;
      if (wr_arr) arr_pre <= wr_data;
      if (wr_cmp && !ctrl_q.cmp_pe) cmp_act <= wr_data;
      else if (upd)                 cmp_act <= cmp_pre;
      if (wr_arr && !ctrl_q.arr_pe) arr_act <= wr_data;
      else if (upd)                 arr_act <= arr_pre;
    end
  end
endmodule

// File: rtl/pt_core.sv
`timescale 1ns/1ps
module pt_core
  import pt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         oneshot,
  input  logic         mode2,
  input  logic         fast_en,
  input  logic         pol,
  input  logic [2:0]   sm,
  input  logic [W-1:0] cmp,
  input  logic [W-1:0] arr,
  input  logic         ug,
  input  logic         run_wr,
  input  logic         run_val,
  input  logic         trig_lvl,
  input  logic         trig_rise,
  output logic         upd,
  output logic [W-1:0] cnt_q,
  output logic         cen_q,
  output logic         fast_q,
  output logic         pulse_q
);
  logic start, reinit, count_en, wrap, ge, ref_lvl;

  assign start    = trig_rise && (sm == SM_TRIG);
  assign reinit   = trig_rise && (sm == SM_RESET);
  assign count_en = cen_q && ((sm != SM_GATED) || trig_lvl);
  assign wrap     = count_en && (cnt_q == arr);
  assign upd      = ug || reinit || wrap;
  assign ge       = (cnt_q >= cmp);
  assign ref_lvl  = fast_q ? mode2 : (mode2 ? ge : !ge);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      cen_q   <= 1'b0;
      fast_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (ug || reinit)  cnt_q <= '0;
      else if (wrap)     cnt_q <= '0;
      else if (count_en) cnt_q <= cnt_q + 1'b1;

      if (run_wr)                cen_q <= run_val;
      else if (start)            cen_q <= 1'b1;
      else if (wrap && oneshot)  cen_q <= 1'b0;

      if (upd)                                 fast_q <= 1'b0;
      else if (start && fast_en && !cen_q)     fast_q <= 1'b1;

      pulse_q <= ref_lvl ^ pol;
    end
  end
endmodule

// File: rtl/pulse_timer.sv
`timescale 1ns/1ps
module pulse_timer
  import pt_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         trig_a,
  input  logic         trig_b,
  output logic         pulse_out
);
  localparam int N_TRIG = 2;

  ctrl_t        ctrl_q;
  logic [W-1:0] cmp_act, arr_act, cnt_q;
  logic         ug, run_wr, run_val, upd;
  logic         cen_q, fast_q, trig_lvl, trig_rise;
  logic [N_TRIG-1:0] trig_raw, trig_sync;

  assign trig_raw = {trig_b, trig_a};

  for (genvar g = 0; g < N_TRIG; g++) begin : g_sync
    pt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .din(trig_raw[g]), .dout(trig_sync[g])
    );
  end

  pt_trig u_trig (
    .clk(clk), .rst(rst), .lvl(trig_sync), .sel(ctrl_q.ts),
    .trig_lvl(trig_lvl), .trig_rise(trig_rise)
  );

  pt_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .upd(upd), .ctrl_q(ctrl_q), .cmp_act(cmp_act), .arr_act(arr_act),
    .ug(ug), .run_wr(run_wr), .run_val(run_val)
  );

  pt_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .oneshot(ctrl_q.oneshot), .mode2(ctrl_q.mode2),
    .fast_en(ctrl_q.fast), .pol(ctrl_q.pol), .sm(ctrl_q.sm),
    .cmp(cmp_act), .arr(arr_act), .ug(ug), .run_wr(run_wr), .run_val(run_val),
    .trig_lvl(trig_lvl), .trig_rise(trig_rise), .upd(upd), .cnt_q(cnt_q),
    .cen_q(cen_q), .fast_q(fast_q), .pulse_q(pulse_out)
  );
endmodule

// File: rtl/pt_chk.sv
`timescale 1ns/1ps
module pt_chk
  import pt_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input ctrl_t        ctrl,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cmp_act,
  input logic [W-1:0] arr_act,
  input logic         upd,
  input logic         ug,
  input logic         run_wr,
  input logic         trig_lvl,
  input logic         trig_rise,
  input logic         cen,
  input logic         fast,
  input logic         pulse
);
  // R1: one-shot wrap stops the counter at zero
  a_r1_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
    (cen && cnt == arr_act && ctrl.oneshot && ctrl.sm != SM_GATED && !run_wr && !trig_rise)
    |=> (!cen && cnt == '0));

  // R3: mode 2 output follows count >= compare one cycle later
  a_r3_mode2_ref: assert property (@(posedge clk) disable iff (rst)
    (ctrl.mode2 && !ctrl.pol && !fast) |=> (pulse == ($past(cnt) >= $past(cmp_act))));

  // R6: trigger-mode edge sets run enable
  a_r6_trig_start: assert property (@(posedge clk) disable iff (rst)
    (trig_rise && ctrl.sm == SM_TRIG && !run_wr) |=> cen);

  // R7: reset-mode edge clears the count
  a_r7_reset_mode: assert property (@(posedge clk) disable iff (rst)
    (trig_rise && ctrl.sm == SM_RESET) |=> (cnt == '0));

  // R8: gated mode holds the count while the gate is low
  a_r8_gate_hold: assert property (@(posedge clk) disable iff (rst)
    (ctrl.sm == SM_GATED && !trig_lvl && !ug) |=> $stable(cnt));

  // R9: buffered compare changes only at update
  a_r9_cmp_buffered: assert property (@(posedge clk) disable iff (rst)
    (ctrl.cmp_pe && !upd) |=> $stable(cmp_act));

  // R10: buffered auto-reload changes only at update
  a_r10_arr_buffered: assert property (@(posedge clk) disable iff (rst)
    (ctrl.arr_pe && !upd) |=> $stable(arr_act));

  // R11: forced level while the fast flag is held
  a_r11_fast_level: assert property (@(posedge clk) disable iff (rst)
    fast |=> (pulse == ($past(ctrl.mode2) ^ $past(ctrl.pol))));

  // R13: update command clears the count
  a_r13_ug_clear: assert property (@(posedge clk) disable iff (rst)
    ug |=> (cnt == '0));
endmodule

bind pulse_timer pt_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .ctrl(ctrl_q), .cnt(cnt_q), .cmp_act(cmp_act),
  .arr_act(arr_act), .upd(upd), .ug(ug), .run_wr(run_wr), .trig_lvl(trig_lvl),
  .trig_rise(trig_rise), .cen(cen_q), .fast(fast_q), .pulse(pulse_out)
);

// File: tb/pulse_timer_test.sv
`timescale 1ns/1ps
module pulse_timer_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic trig_a = 1'b0;
  logic trig_b = 1'b0;
  logic pulse_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pulse_timer #(.W(W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trig_a(trig_a), .trig_b(trig_b), .pulse_out(pulse_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mkc(bit os, bit m2, bit fa, bit cpe, bit ape,
                                       bit pol, logic [2:0] ts, logic [2:0] sm, bit run);
    return {3'b000, run, sm, ts, pol, ape, cpe, fa, m2, os};
  endfunction

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d[W-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(input int cmp, input int arr, input logic [W-1:0] c);
    wr(2'd2, arr);
    wr(2'd1, cmp);
    wr(2'd0, int'(c));
    wr(2'd3, 1);
  endtask

  task automatic quiet();
    wr(2'd0, 0);
    trig_a = 1'b0; trig_b = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic kick(input int ch, input logic v);
    @(negedge clk);
    if (ch == 0) trig_a = v; else trig_b = v;
  endtask

  task automatic observe(input int n, input logic act, output int r, output int f, output int r2);
    r = -1; f = -1; r2 = -1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (pulse_out == act) begin
        if (r < 0) r = i;
        else if (f >= 0 && r2 < 0) r2 = i;
      end else if (r >= 0 && f < 0) begin
        f = i;
      end
    end
  endtask

  initial begin
    int r, f, r2;
    void'($urandom(32'd4711));
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk("R14 reset output low", int'(pulse_out), 0);

    // R1 R2 R6: one-shot, mode 2, trigger mode on input B
    quiet();
    cfg(5, 12, mkc(1,1,0,0,0,0,3'b110,3'b110,0));
    kick(1, 1'b1);
    observe(30, 1'b1, r, f, r2);
    chk("R2 rise index", r, 8);
    chk("R2 fall index", f, 16);
    chk("R1 one-shot no second pulse", r2, -1);

    // R1 repetitive
    quiet();
    cfg(5, 12, mkc(0,1,0,0,0,0,3'b110,3'b110,0));
    kick(1, 1'b1);
    observe(40, 1'b1, r, f, r2);
    chk("R1 repeat first rise", r, 8);
    chk("R1 repeat fall", f, 16);
    chk("R1 repeat second rise", r2, 21);

    // R11 fast
    quiet();
    cfg(5, 12, mkc(1,1,1,0,0,0,3'b110,3'b110,0));
    kick(1, 1'b1);
    observe(30, 1'b1, r, f, r2);
    chk("R11 fast rise index", r, 3);
    chk("R11 fast fall index", f, 16);

    // R12 polarity
    quiet();
    cfg(5, 12, mkc(1,1,0,0,0,1,3'b110,3'b110,0));
    kick(1, 1'b1);
    observe(30, 1'b0, r, f, r2);
    chk("R12 active-low start", r, 8);
    chk("R12 active-low end", f, 16);

    // R3 mode 1
    quiet();
    cfg(5, 12, mkc(1,0,0,0,0,0,3'b110,3'b110,0));
    @(negedge clk);
    chk("R3 mode1 idle active", int'(pulse_out), 1);
    kick(1, 1'b1);
    observe(30, 1'b0, r, f, r2);
    chk("R3 mode1 drop at match", r, 8);
    chk("R3 mode1 restore at wrap", f, 16);

    // R4 compare above auto-reload
    quiet();
    cfg(50, 20, mkc(1,1,0,0,0,0,3'b110,3'b110,0));
    kick(1, 1'b1);
    observe(40, 1'b1, r, f, r2);
    chk("R4 no pulse", r, -1);

    // R5 unselected input ignored, then input A level
    quiet();
    cfg(5, 12, mkc(1,1,0,0,0,0,3'b110,3'b110,0));
    kick(0, 1'b1);
    observe(30, 1'b1, r, f, r2);
    chk("R5 unselected input ignored", r, -1);
    quiet();
    cfg(5, 12, mkc(1,1,0,0,0,0,3'b101,3'b110,0));
    kick(0, 1'b1);
    observe(30, 1'b1, r, f, r2);
    chk("R5 input A level trigger", r, 8);

    // R5 edge detector fires on a falling edge of A
    quiet();
    trig_a = 1'b1;
    repeat (4) @(negedge clk);
    cfg(5, 12, mkc(1,1,0,0,0,0,3'b100,3'b110,0));
    kick(0, 1'b0);
    observe(30, 1'b1, r, f, r2);
    chk("R5 edge detector falling edge", r, 8);

    // R7 reset mode restarts a running count
    quiet();
    cfg(10, 200, mkc(0,1,0,0,0,0,3'b110,3'b100,1));
    kick(1, 1'b1);
    observe(20, 1'b1, r, f, r2);
    chk("R7 reset-mode rise index", r, 13);

    // R8 gated mode
    quiet();
    cfg(6, 100, mkc(0,1,0,0,0,0,3'b110,3'b101,1));
    kick(1, 1'b1);
    repeat (3) @(negedge clk);
    trig_b = 1'b0;
    repeat (20) @(negedge clk);
    chk("R8 count held while gate low", int'(pulse_out), 0);
    kick(1, 1'b1);
    observe(20, 1'b1, r, f, r2);
    chk("R8 resumed rise index", r, 5);

    // R9 R10 R13 buffering and update command
    quiet();
    cfg(2, 20, mkc(1,1,0,1,1,0,3'b110,3'b110,0));
    wr(2'd1, 4);
    wr(2'd3, 1);
    wr(2'd1, 9);
    wr(2'd2, 30);
    kick(1, 1'b1);
    observe(40, 1'b1, r, f, r2);
    chk("R13 update loaded compare", r, 7);
    chk("R10 buffered reload not yet active", f, 24);
    trig_b = 1'b0;
    repeat (3) @(negedge clk);
    kick(1, 1'b1);
    observe(50, 1'b1, r, f, r2);
    chk("R9 compare copied at wrap", r, 12);
    chk("R10 reload copied at wrap", f, 34);

    // R2 R11 R12 random settings
    for (int k = 0; k < 6; k++) begin
      int cmp, arr, ch;
      bit fa, pl;
      cmp = 1 + int'($urandom % 20);
      arr = cmp + int'($urandom % 30);
      fa  = bit'($urandom % 2);
      pl  = bit'($urandom % 2);
      ch  = int'($urandom % 2);
      quiet();
      cfg(cmp, arr, mkc(1,1,fa,0,0,pl, (ch == 0) ? 3'b101 : 3'b110, 3'b110, 0));
      kick(ch, 1'b1);
      observe(arr + 10, !pl, r, f, r2);
      chk("R2/R11 random rise", r, fa ? 3 : cmp + 3);
      chk("R2/R12 random fall", f, arr + 4);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule